// File: doc/BRIEF.md
# DRAM Write-to-Read Turnaround Checker

This block guards the data strobe of a DRAM controller against write-to-read turnaround violations. The scheduler keeps a record of every command it places by presenting it on the commit port. The block keeps the recent writes, each with its issue cycle, the cycle at which its data burst leaves the strobe, and its bank. It also keeps the recent reads, each with its start cycle and its bank. A candidate command is presented on the query port, and a combinational permit flag reports whether that command may be placed at the candidate cycle.

The data burst of a write ends at its issue cycle plus the write latency plus half the burst length, since the burst is double data rate. The turnaround gap after that end is the long value when the write and the read fall in the same bank group and the short value otherwise. A read query is checked against every stored write that issued no later than it. A write query is checked in the reverse direction, against every stored read that starts at or after it. All entries are compared in parallel.

Commits carry no handshake and are always accepted. The histories have a fixed depth. When a history is full, the oldest entry is overwritten. Entries that can no longer constrain any query at or after the current cycle `now` are retired on their own. Devices without bank groups program both gap registers to the same value.

Top module: `wtr_turnaround_chk`

## Requirements
- R1: A read query at cycle c is denied when a stored write with issue cycle i <= c has c < end + gap, where end = i + WL + BL/2 uses the WL and BL values present when the write was committed. Otherwise the stored write does not deny the read.
- R2: The gap is cfg_twtr_l when the two banks are in the same group and cfg_twtr_s otherwise, where group = bank / NUM_BG in integer division. The gap uses the register values present at query time.
- R3: A write query at cycle c is denied when a stored read with start s has c <= s < c + WL + BL/2 + gap, using the current WL and BL.
- R4: A stored write does not restrict a read query at an earlier cycle than the write's issue cycle. A stored read does not restrict a write query at a later cycle than the read's start.
- R5: After reset both histories are empty, and every query is permitted.
- R6: A committed command affects queries from the next clock cycle onward. A query in the same cycle as the commit is answered without it.
- R7: The write history holds WR_DEPTH entries. A write committed while all entries are live replaces the entry with the earliest data end, the lowest slot on a tie.
- R8: The read history holds RD_DEPTH entries. A read committed while all entries are live replaces the entry with the earliest start, the lowest slot on a tie.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now | input | CYC_W | Current cycle count; every query cycle must be at or after it |
| cfg_wl | input | 8 | Write latency in cycles |
| cfg_bl | input | 8 | Burst length in beats |
| cfg_twtr_s | input | 8 | Turnaround gap between banks of different groups |
| cfg_twtr_l | input | 8 | Turnaround gap between banks of the same group |
| q_is_write | input | 1 | Query kind: 1 = write, 0 = read |
| q_bank | input | BANK_W | Query bank |
| q_cycle | input | CYC_W | Candidate issue cycle of the query |
| q_permit | output | 1 | 1 when the query violates no turnaround rule |
| cm_valid | input | 1 | Record a placed command this cycle |
| cm_is_write | input | 1 | Recorded kind: 1 = write, 0 = read |
| cm_bank | input | BANK_W | Recorded bank |
| cm_cycle | input | CYC_W | Recorded issue cycle |

## Verification
The bench first tries a single stored write against read queries swept over every bank and over a window of cycles around the write. This shows where the long gap applies and where the short one does. It also shows that reads before the write's issue are free. A single stored read is then swept with write queries, which exercises the reverse rule and the exclusion of later writes. Filling each history past its depth shows which entry is dropped. Changing WL after a write is recorded shows that the stored data end is frozen at commit time. A long pseudo-random run of commits, moving `now` forward and changing the gap registers, compares both query kinds over all banks against an arithmetic model.

// File: rtl/wtr_pkg.sv
package wtr_pkg;
  localparam int LAT_W = 8;
  typedef enum logic {KIND_RD = 1'b0, KIND_WR = 1'b1} kind_e;
endpackage

// File: rtl/wtr_hist.sv
// Fixed-depth history of timed entries. The key is the cycle used for
// retirement and replacement; data is an opaque payload.
module wtr_hist #(
  parameter int DEPTH  = 4,
  parameter int KEY_W  = 24,
  parameter int DATA_W = 4,
  parameter int MARG_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [KEY_W-1:0]              now,
  input  logic [MARG_W-1:0]             margin,
  input  logic                          ins_en,
  input  logic [KEY_W-1:0]              ins_key,
  input  logic [DATA_W-1:0]             ins_data,
  output logic [DEPTH-1:0]              vld,
  output logic [DEPTH-1:0][KEY_W-1:0]   key,
  output logic [DEPTH-1:0][DATA_W-1:0]  data
);
  logic [DEPTH-1:0] retire;
  logic [IDX_W-1:0] sel;
  logic             found;
  logic [KEY_W-1:0] best;

  // an entry retires once key + margin has been reached by now
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      retire[i] = vld[i] &&
                  (({1'b0, key[i]} + (KEY_W+1)'(margin)) <= {1'b0, now});
    end
  end

  // slot choice: lowest free slot, else the live entry with the smallest key
  always_comb begin
    found = 1'b0;
    sel   = '0;
    best  = key[0];
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && (!vld[i] || retire[i])) begin
        found = 1'b1;
        sel   = IDX_W'(i);
      end
    end
    if (!found) begin
      for (int i = 1; i < DEPTH; i++) begin
        if (key[i] < best) begin
          best = key[i];
          sel  = IDX_W'(i);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ins_en && (sel == IDX_W'(i))) vld[i] <= 1'b1;
        else if (retire[i])               vld[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (ins_en && (sel == IDX_W'(i))) begin
        key[i]  <= ins_key;
        data[i] <= ins_data;
      end
    end
  end
endmodule

// File: rtl/wtr_match.sv
// One write/read pair: does the read start fall inside the write's
// data end plus the bank-group-dependent gap?
module wtr_match #(
  parameter int CYC_W  = 24,
  parameter int BANK_W = 4,
  parameter int NUM_BG = 4,
  parameter int LAT_W  = 8
) (
  input  logic              vld,
  input  logic [CYC_W-1:0]  wr_issue,
  input  logic [CYC_W-1:0]  wr_end,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [CYC_W-1:0]  rd_start,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [LAT_W-1:0]  twtr_s,
  input  logic [LAT_W-1:0]  twtr_l,
  output logic              hit
);
  logic             same_grp;
  logic [LAT_W-1:0] gap;
  logic [CYC_W:0]   limit;

  assign same_grp = (wr_bank / BANK_W'(NUM_BG)) == (rd_bank / BANK_W'(NUM_BG));
  assign gap      = same_grp ? twtr_l : twtr_s;
  assign limit    = {1'b0, wr_end} + (CYC_W+1)'(gap);
  assign hit      = vld && (rd_start >= wr_issue) && ({1'b0, rd_start} < limit);
endmodule

// File: rtl/wtr_turnaround_chk.sv
module wtr_turnaround_chk #(
  parameter int CYC_W     = 24,
  parameter int NUM_BANKS = 16,
  parameter int NUM_BG    = 4,
  parameter int WR_DEPTH  = 4,
  parameter int RD_DEPTH  = 4,
  localparam int LAT_W    = wtr_pkg::LAT_W,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CYC_W-1:0]  now,
  input  logic [LAT_W-1:0]  cfg_wl,
  input  logic [LAT_W-1:0]  cfg_bl,
  input  logic [LAT_W-1:0]  cfg_twtr_s,
  input  logic [LAT_W-1:0]  cfg_twtr_l,
  input  logic              q_is_write,
  input  logic [BANK_W-1:0] q_bank,
  input  logic [CYC_W-1:0]  q_cycle,
  output logic              q_permit,
  input  logic              cm_valid,
  input  logic              cm_is_write,
  input  logic [BANK_W-1:0] cm_bank,
  input  logic [CYC_W-1:0]  cm_cycle
);
  import wtr_pkg::*;

  localparam int WR_DW = CYC_W + BANK_W;

  logic [CYC_W-1:0] span_now, q_end, cm_end;
  kind_e            q_kind;

  logic [WR_DEPTH-1:0]             wr_vld, wr_hit;
  logic [WR_DEPTH-1:0][CYC_W-1:0]  wr_end;
  logic [WR_DEPTH-1:0][WR_DW-1:0]  wr_data;
  logic [RD_DEPTH-1:0]             rd_vld, rd_hit;
  logic [RD_DEPTH-1:0][CYC_W-1:0]  rd_start;
  logic [RD_DEPTH-1:0][BANK_W-1:0] rd_bank;

  // double data rate: a burst of BL beats occupies BL/2 cycles
  assign span_now = CYC_W'(cfg_wl) + CYC_W'(cfg_bl >> 1);
  assign q_end    = q_cycle + span_now;
  assign cm_end   = cm_cycle + span_now;
  assign q_kind   = kind_e'(q_is_write);

  wtr_hist #(
    .DEPTH(WR_DEPTH), .KEY_W(CYC_W), .DATA_W(WR_DW), .MARG_W(LAT_W)
  ) u_wr_hist (
    .clk(clk), .rst_n(rst_n), .now(now), .margin(cfg_twtr_l),
    .ins_en(cm_valid && cm_is_write), .ins_key(cm_end),
    .ins_data({cm_cycle, cm_bank}),
    .vld(wr_vld), .key(wr_end), .data(wr_data)
  );

  wtr_hist #(
    .DEPTH(RD_DEPTH), .KEY_W(CYC_W), .DATA_W(BANK_W), .MARG_W(LAT_W)
  ) u_rd_hist (
    .clk(clk), .rst_n(rst_n), .now(now), .margin(LAT_W'(1)),
    .ins_en(cm_valid && !cm_is_write), .ins_key(cm_cycle),
    .ins_data(cm_bank),
    .vld(rd_vld), .key(rd_start), .data(rd_bank)
  );

  // stored writes against a candidate read
  for (genvar gi = 0; gi < WR_DEPTH; gi++) begin : g_wr_cmp
    wtr_match #(
      .CYC_W(CYC_W), .BANK_W(BANK_W), .NUM_BG(NUM_BG), .LAT_W(LAT_W)
    ) u_cmp (
      .vld(wr_vld[gi]),
      .wr_issue(wr_data[gi][BANK_W +: CYC_W]),
      .wr_end(wr_end[gi]),
      .wr_bank(wr_data[gi][BANK_W-1:0]),
      .rd_start(q_cycle), .rd_bank(q_bank),
      .twtr_s(cfg_twtr_s), .twtr_l(cfg_twtr_l),
      .hit(wr_hit[gi])
    );
  end

  // candidate write against stored reads
  for (genvar gj = 0; gj < RD_DEPTH; gj++) begin : g_rd_cmp
    wtr_match #(
      .CYC_W(CYC_W), .BANK_W(BANK_W), .NUM_BG(NUM_BG), .LAT_W(LAT_W)
    ) u_cmp (
      .vld(rd_vld[gj]),
      .wr_issue(q_cycle), .wr_end(q_end), .wr_bank(q_bank),
      .rd_start(rd_start[gj]), .rd_bank(rd_bank[gj]),
      .twtr_s(cfg_twtr_s), .twtr_l(cfg_twtr_l),
      .hit(rd_hit[gj])
    );
  end

  always_comb begin
    unique case (q_kind)
      KIND_WR: q_permit = !(|rd_hit);
      default: q_permit = !(|wr_hit);
    endcase
  end
endmodule

// File: rtl/wtr_turnaround_sva.sv
module wtr_turnaround_sva #(
  parameter int CYC_W    = 24,
  parameter int WR_DEPTH = 4,
  parameter int RD_DEPTH = 4,
  parameter int LAT_W    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cm_valid,
  input logic                cm_is_write,
  input logic [CYC_W-1:0]    cm_cycle,
  input logic [LAT_W-1:0]    cfg_wl,
  input logic                q_is_write,
  input logic [CYC_W-1:0]    q_cycle,
  input logic                q_permit,
  input logic [WR_DEPTH-1:0] wr_vld,
  input logic [RD_DEPTH-1:0] rd_vld
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_empty_permit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|wr_vld) && !(|rd_vld)) |-> q_permit);

  p_kept_after_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cm_valid && cm_is_write)) |-> (|wr_vld));

  p_grow_by_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ($countones(wr_vld) <= $past($countones(wr_vld)) + 1));

  p_fresh_write_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cm_valid && cm_is_write && (cfg_wl != '0)) &&
     !q_is_write && (q_cycle == $past(cm_cycle))) |-> !q_permit);

  p_fresh_read_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cm_valid && !cm_is_write) && q_is_write &&
     (cfg_wl != '0) && (q_cycle == $past(cm_cycle))) |-> !q_permit);
endmodule

bind wtr_turnaround_chk wtr_turnaround_sva #(
  .CYC_W(CYC_W), .WR_DEPTH(WR_DEPTH), .RD_DEPTH(RD_DEPTH), .LAT_W(LAT_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .cm_valid(cm_valid), .cm_is_write(cm_is_write),
  .cm_cycle(cm_cycle), .cfg_wl(cfg_wl), .q_is_write(q_is_write),
  .q_cycle(q_cycle), .q_permit(q_permit), .wr_vld(wr_vld), .rd_vld(rd_vld)
);

// File: tb/test_wtr_turnaround_chk.sv
module test_wtr_turnaround_chk;
  localparam int CLK_PERIOD = 10000;
  localparam int CYC_W = 24;
  localparam int NB    = 8;
  localparam int NG    = 2;
  localparam int WD    = 4;
  localparam int RD    = 4;
  localparam int BW    = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CYC_W-1:0] now = '0;
  logic [7:0]       cfg_wl = 8'd4, cfg_bl = 8'd8, cfg_twtr_s = 8'd2, cfg_twtr_l = 8'd6;
  logic             q_is_write = 1'b0;
  logic [BW-1:0]    q_bank = '0;
  logic [CYC_W-1:0] q_cycle = '0;
  logic             q_permit;
  logic             cm_valid = 1'b0, cm_is_write = 1'b0;
  logic [BW-1:0]    cm_bank = '0;
  logic [CYC_W-1:0] cm_cycle = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state
  int mw_v[WD], mw_iss[WD], mw_end[WD], mw_bk[WD];
  int mr_v[RD], mr_st[RD], mr_bk[RD];

  wtr_turnaround_chk #(.CYC_W(CYC_W), .NUM_BANKS(NB), .NUM_BG(NG),
                       .WR_DEPTH(WD), .RD_DEPTH(RD)) i_wtr_turnaround_chk (
    .clk(clk), .rst_n(rst_n), .now(now), .cfg_wl(cfg_wl), .cfg_bl(cfg_bl),
    .cfg_twtr_s(cfg_twtr_s), .cfg_twtr_l(cfg_twtr_l),
    .q_is_write(q_is_write), .q_bank(q_bank), .q_cycle(q_cycle),
    .q_permit(q_permit), .cm_valid(cm_valid), .cm_is_write(cm_is_write),
    .cm_bank(cm_bank), .cm_cycle(cm_cycle));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int gap(int a, int b);
    return ((a / NG) == (b / NG)) ? int'(cfg_twtr_l) : int'(cfg_twtr_s);
  endfunction

  function automatic bit model_permit(bit isw, int bank, int c);
    int span = int'(cfg_wl) + int'(cfg_bl) / 2;
    if (!isw) begin
      for (int i = 0; i < WD; i++)
        if (mw_v[i] != 0 && c >= mw_iss[i] && c < mw_end[i] + gap(mw_bk[i], bank)) return 0;
    end else begin
      for (int i = 0; i < RD; i++)
        if (mr_v[i] != 0 && mr_st[i] >= c && mr_st[i] < c + span + gap(bank, mr_bk[i])) return 0;
    end
    return 1;
  endfunction

  // mirrors one clock edge of the histories, per R6/R7/R8 and retirement
  task automatic model_edge();
    int n = int'(now);
    bit wret[WD];
    bit rret[RD];
    int sel, best;
    bit fnd;
    for (int i = 0; i < WD; i++) wret[i] = mw_v[i] != 0 && mw_end[i] + int'(cfg_twtr_l) <= n;
    for (int i = 0; i < RD; i++) rret[i] = mr_v[i] != 0 && mr_st[i] + 1 <= n;
    if (cm_valid && cm_is_write) begin
      fnd = 0; sel = 0;
      for (int i = 0; i < WD; i++) if (!fnd && (mw_v[i] == 0 || wret[i])) begin fnd = 1; sel = i; end
      if (!fnd) begin best = mw_end[0]; for (int i = 1; i < WD; i++) if (mw_end[i] < best) begin best = mw_end[i]; sel = i; end end
      wret[sel] = 0;
      mw_v[sel] = 1; mw_iss[sel] = int'(cm_cycle);
      mw_end[sel] = int'(cm_cycle) + int'(cfg_wl) + int'(cfg_bl) / 2; mw_bk[sel] = int'(cm_bank);
    end
    if (cm_valid && !cm_is_write) begin
      fnd = 0; sel = 0;
      for (int i = 0; i < RD; i++) if (!fnd && (mr_v[i] == 0 || rret[i])) begin fnd = 1; sel = i; end
      if (!fnd) begin best = mr_st[0]; for (int i = 1; i < RD; i++) if (mr_st[i] < best) begin best = mr_st[i]; sel = i; end end
      rret[sel] = 0;
      mr_v[sel] = 1; mr_st[sel] = int'(cm_cycle); mr_bk[sel] = int'(cm_bank);
    end
    for (int i = 0; i < WD; i++) if (wret[i]) mw_v[i] = 0;
    for (int i = 0; i < RD; i++) if (rret[i]) mr_v[i] = 0;
  endtask

  task automatic edge_step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cm_valid = 1'b0;
  endtask

  task automatic check(string tag, bit got, bit exp, int b, int c, bit isw);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s kind=%0b bank=%0d cycle=%0d permit actual=%0b expected=%0b",
               tag, isw, b, c, got, exp);
    end
  endtask

  task automatic query(string tag, bit isw, int b, int c, bit exp);
    q_is_write = isw; q_bank = BW'(b); q_cycle = CYC_W'(c);
    #1;
    check(tag, q_permit, exp, b, c, isw);
  endtask

  // all banks over [c0, c1]; stays well inside half a clock period
  task automatic sweep(string tag, bit isw, int c0, int c1);
    for (int b = 0; b < NB; b++)
      for (int c = c0; c <= c1; c++)
        query(tag, isw, b, c, model_permit(isw, b, c));
  endtask

  task automatic commit(bit isw, int b, int c);
    cm_valid = 1'b1; cm_is_write = isw; cm_bank = BW'(b); cm_cycle = CYC_W'(c);
    edge_step();
  endtask

  int unsigned seed = 32'h1234_5678;
  function automatic int rnd(int m);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'((seed >> 8) % m);
  endfunction

  initial begin
    for (int i = 0; i < WD; i++) mw_v[i] = 0;
    for (int i = 0; i < RD; i++) mr_v[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: empty after reset, everything permitted
    sweep("R5", 0, 0, 15);
    sweep("R5", 1, 0, 15);

    // R1/R2/R4: one write, bank 2, issue 20, end 28
    commit(1, 2, 20);
    sweep("R1", 0, 10, 40);
    query("R2", 0, 3, 33, 0);  // same group: 28+6
    query("R2", 0, 3, 34, 1);
    query("R2", 0, 4, 29, 0);  // other group: 28+2
    query("R2", 0, 4, 30, 1);
    query("R4", 0, 2, 19, 1);  // read before the write issued
    cfg_twtr_l = 8'd9;         // R2: current register value is used
    query("R2", 0, 3, 36, 0);
    query("R2", 0, 3, 37, 1);
    cfg_twtr_l = 8'd6;

    // R6: query in the commit cycle sees nothing new
    cm_valid = 1'b1; cm_is_write = 1'b1; cm_bank = 3'd0; cm_cycle = 24'd50;
    query("R6", 0, 0, 50, 1);
    edge_step();
    query("R6", 0, 0, 50, 0);

    // R3/R4: one read, bank 5, start 80
    commit(0, 5, 80);
    sweep("R3", 1, 60, 90);
    query("R3", 1, 4, 66, 1);
    query("R3", 1, 4, 67, 0);
    query("R3", 1, 0, 70, 1);
    query("R3", 1, 0, 71, 0);
    query("R4", 1, 5, 81, 1);  // write after the read

    // R7: fill the write history, then one more drops end 28
    commit(1, 0, 100);
    commit(1, 2, 110);
    query("R7", 0, 2, 25, 0);
    commit(1, 4, 120);
    query("R7", 0, 2, 25, 1);
    sweep("R7", 0, 20, 130);

    // R8: fill the read history, then one more drops start 80
    commit(0, 6, 130);
    commit(0, 1, 140);
    commit(0, 7, 150);
    query("R8", 1, 4, 70, 0);
    commit(0, 2, 160);
    query("R8", 1, 4, 70, 1);
    sweep("R8", 1, 60, 170);

    // R1: stored data ends are frozen when WL changes later
    cfg_wl = 8'd10;
    sweep("R1", 0, 20, 140);
    query("R1", 0, 4, 130, 0);  // end 128 + 6 from the stored burst
    query("R1", 0, 4, 134, 1);
    cfg_wl = 8'd4;

    // mixed pseudo-random traffic with time moving forward
    now = 24'd200;
    for (int it = 0; it < 80; it++) begin
      now = now + CYC_W'(rnd(6));
      if (rnd(4) == 0) begin
        cfg_twtr_s = 8'(rnd(4));
        cfg_twtr_l = cfg_twtr_s + 8'(rnd(5));
      end
      commit(rnd(2) == 1, rnd(NB), int'(now) + rnd(20));
      sweep("R1", 0, int'(now), int'(now) + 35);
      sweep("R3", 1, int'(now), int'(now) + 35);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(64'(CLK_PERIOD) * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule